// File: doc/BRIEF.md
# Packed Greater-Than Comparator

This block compares two packed vector operands lane by lane and returns a lane mask. A lane is filled with ones when the first operand's lane is strictly greater than the second's. Otherwise it is filled with zeros. Lane boundaries are chosen per operation. Integer lanes can be 8, 16 or 32 bits wide. The lanes can be read as signed integers, unsigned integers or single-precision floating-point values, and all three orderings share one datapath. A narrow form restricts the result to the lower half of the vector. A zero-compare form tests the first operand against zero and ignores the second.

The block is built for a SIMD execution pipe. Operations enter on a valid/ready input handshake, and results leave on a valid/ready output handshake one cycle later. The output register stalls when its consumer stalls. `in_ready` is high when the output register is empty or is being drained in the same cycle, so a full-rate stream runs with no bubbles while `out_ready` stays high. When `out_ready` drops, `out_valid` and `mask` hold until the result is taken, and `in_ready` falls in the same cycle. Apart from the mask, no flag or status output exists.

Top module: `simd_gt_cmp`

## Requirements
- R1: Comparison is strict. A lane whose two values are equal yields all zeros.
- R2: Every result lane is exactly as wide as its operand lane and is either all ones (test passed) or all zeros (test failed).
- R3: For integer kinds, `lane_sz` selects the lane width: 2'b00 gives 8 bits, 2'b01 gives 16 bits, 2'b10 and 2'b11 give 32 bits.
- R4: `num_kind` selects the ordering: 2'b00 is two's-complement signed, 2'b01 is unsigned, and 2'b10 or 2'b11 is single precision (sign bit 31, exponent bits 30:23, fraction bits 22:0). Floating-point lanes are always 32 bits wide, whatever `lane_sz` holds.
- R5: In floating-point mode, a lane in which either value is a NaN (exponent all ones, fraction nonzero) yields all zeros.
- R6: In floating-point mode, values with a zero exponent (zeros and denormals) are treated as zero of their sign, and zeros of either sign compare equal. Infinities order normally.
- R7: When `half_width` is 1, mask bits 127:64 are zero and bits 63:0 carry the normal result.
- R8: When `zero_mode` is 1, every lane of `opa` is compared with zero and `opb` has no effect on the result.
- R9: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its mask appears with `out_valid` after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `mask` and `out_valid` hold.
- R10: A synchronous active-high `rst` clears `out_valid` and `mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| opa | input | 128 | First operand (left of the greater-than) |
| opb | input | 128 | Second operand |
| lane_sz | input | 2 | Integer lane width code |
| num_kind | input | 2 | Ordering kind: signed, unsigned, floating point |
| half_width | input | 1 | Restrict the result to the lower 64 bits |
| zero_mode | input | 1 | Compare opa against zero |
| out_valid | output | 1 | Result register holds a mask |
| out_ready | input | 1 | Consumer takes the mask this cycle |
| mask | output | 128 | Per-lane result mask |

## Verification
The bench sends lanes that are equal, lanes that differ only in the sign bit, and lanes whose upper bytes are equal while the lower bytes differ. A design that used a non-strict comparison, mixed up signed and unsigned order, or chained byte results wrongly at 16 or 32 bits would return the wrong lane values for these inputs. Floating-point cases cover NaN on either side, +0 against -0, denormals against zero and against negative zero, infinities, and negative-versus-negative ordering. A comparator that skipped the NaN test, skipped denormal flushing, or ordered sign-magnitude values as plain integers would set lanes it should clear. Random runs with back-pressure on the output catch a mask that changes while stalled, and separate runs catch opb leaking into zero mode and the upper half leaking through in the narrow form.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  typedef enum logic [1:0] {
    KIND_SINT = 2'b00,
    KIND_UINT = 2'b01,
    KIND_FP   = 2'b10,
    KIND_FP2  = 2'b11
  } num_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } lane_sz_e;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;

endpackage

// File: rtl/simd_int_gt.sv
module simd_int_gt
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0]          a,
  input  logic [DATA_W-1:0]          b,
  input  logic                       is_signed,
  input  logic [1:0]                 sz,
  output logic [DATA_W/BYTE_W-1:0]   byte_gt
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int NH = NB / 2;
  localparam int NW = NB / 4;

  logic [NB-1:0] b_gtu, b_gts, b_eq;
  logic [NH-1:0] h_gtu, h_gts, h_eq;
  logic [NW-1:0] w_gtu, w_gts;
  lane_sz_e sz_e;

  assign sz_e = lane_sz_e'(sz);

  // byte level: unsigned and signed greater-than plus equality
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [BYTE_W-1:0] ab, bb;
    assign ab = a[BYTE_W*i +: BYTE_W];
    assign bb = b[BYTE_W*i +: BYTE_W];
    assign b_gtu[i] = ab > bb;
    assign b_gts[i] = $signed(ab) > $signed(bb);
    assign b_eq[i]  = ab == bb;
  end

  // 16-bit lanes: the high byte decides unless equal, low byte is unsigned
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign h_gtu[h] = b_gtu[2*h+1] | (b_eq[2*h+1] & b_gtu[2*h]);
    assign h_gts[h] = b_gts[2*h+1] | (b_eq[2*h+1] & b_gtu[2*h]);
    assign h_eq[h]  = b_eq[2*h+1] & b_eq[2*h];
  end

  // 32-bit lanes built from the 16-bit partials
  for (genvar w = 0; w < NW; w++) begin : g_word
    assign w_gtu[w] = h_gtu[2*w+1] | (h_eq[2*w+1] & h_gtu[2*w]);
    assign w_gts[w] = h_gts[2*w+1] | (h_eq[2*w+1] & h_gtu[2*w]);
  end

  // broadcast each lane result to every byte it covers
  for (genvar i = 0; i < NB; i++) begin : g_sel
    always_comb begin
      unique case (sz_e)
        SZ_BYTE: byte_gt[i] = is_signed ? b_gts[i]   : b_gtu[i];
        SZ_HALF: byte_gt[i] = is_signed ? h_gts[i/2] : h_gtu[i/2];
        default: byte_gt[i] = is_signed ? w_gts[i/4] : w_gtu[i/4];
      endcase
    end
  end

endmodule

// File: rtl/simd_fp_gt.sv
module simd_fp_gt
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int EXP_W  = FP_EXP_W,
  parameter int MAN_W  = FP_MAN_W
) (
  input  logic [DATA_W-1:0]                 a,
  input  logic [DATA_W-1:0]                 b,
  output logic [DATA_W/(1+EXP_W+MAN_W)-1:0] word_gt
);
  localparam int FW = 1 + EXP_W + MAN_W;
  localparam int NW = DATA_W / FW;
  localparam int MAG_W = EXP_W + MAN_W;

  for (genvar w = 0; w < NW; w++) begin : g_lane
    logic [FW-1:0]    fa, fb;
    logic             sa, sb, nan_a, nan_b, zero_a, zero_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             ord;

    assign fa = a[FW*w +: FW];
    assign fb = b[FW*w +: FW];
    assign sa = fa[FW-1];
    assign sb = fb[FW-1];

    assign nan_a = (&fa[MAG_W-1:MAN_W]) && (|fa[MAN_W-1:0]);
    assign nan_b = (&fb[MAG_W-1:MAN_W]) && (|fb[MAN_W-1:0]);

    // flush: a zero exponent means a zero magnitude
    assign mag_a  = (fa[MAG_W-1:MAN_W] == '0) ? '0 : fa[MAG_W-1:0];
    assign mag_b  = (fb[MAG_W-1:MAN_W] == '0) ? '0 : fb[MAG_W-1:0];
    assign zero_a = mag_a == '0;
    assign zero_b = mag_b == '0;

    always_comb begin
      unique case ({sa, sb})
        2'b01:   ord = 1'b1;
        2'b00:   ord = mag_a > mag_b;
        2'b11:   ord = mag_a < mag_b;
        default: ord = 1'b0;
      endcase
    end

    assign word_gt[w] = !(nan_a || nan_b) && !(zero_a && zero_b) && ord;
  end

endmodule

// File: rtl/simd_mask_expand.sv
module simd_mask_expand
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W/BYTE_W-1:0] byte_res,
  input  logic                     half,
  output logic [DATA_W-1:0]        mask
);
  localparam int NB = DATA_W / BYTE_W;

  for (genvar i = 0; i < NB; i++) begin : g_exp
    if (i >= NB / 2) begin : g_hi
      assign mask[BYTE_W*i +: BYTE_W] = half ? '0 : {BYTE_W{byte_res[i]}};
    end else begin : g_lo
      assign mask[BYTE_W*i +: BYTE_W] = {BYTE_W{byte_res[i]}};
    end
  end

endmodule

// File: rtl/simd_gt_cmp.sv
module simd_gt_cmp
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        lane_sz,
  input  logic [1:0]        num_kind,
  input  logic              half_width,
  input  logic              zero_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] mask
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int NW = DATA_W / WORD_W;
  localparam int BPW = WORD_W / BYTE_W;

  num_kind_e        kind_e;
  logic             is_fp, is_signed, accept;
  logic [DATA_W-1:0] rhs, mask_nxt;
  logic [NB-1:0]    int_res, sel_res;
  logic [NW-1:0]    fp_res;

  assign kind_e    = num_kind_e'(num_kind);
  assign is_fp     = (kind_e == KIND_FP) || (kind_e == KIND_FP2);
  assign is_signed = kind_e == KIND_SINT;
  assign rhs       = zero_mode ? '0 : opb;

  simd_int_gt #(.DATA_W(DATA_W)) int_i (
    .a(opa), .b(rhs), .is_signed(is_signed), .sz(lane_sz), .byte_gt(int_res)
  );

  simd_fp_gt #(.DATA_W(DATA_W)) fp_i (
    .a(opa), .b(rhs), .word_gt(fp_res)
  );

  for (genvar i = 0; i < NB; i++) begin : g_pick
    assign sel_res[i] = is_fp ? fp_res[i/BPW] : int_res[i];
  end

  simd_mask_expand #(.DATA_W(DATA_W)) exp_i (
    .byte_res(sel_res), .half(half_width), .mask(mask_nxt)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mask      <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      mask      <= mask_nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: identical operands never produce a set lane
  p_strict_eq_r1: assert property (@(posedge clk) disable iff (rst)
    (accept && !zero_mode && opa == opb) |=> (mask == '0));

  // R2: every byte of a valid mask is uniform
  for (genvar i = 0; i < NB; i++) begin : g_chk
    p_full_lane_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (mask[BYTE_W*i +: BYTE_W] == '0 || mask[BYTE_W*i +: BYTE_W] == '1));
  end

  // R7: narrow form clears the upper half
  p_half_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && half_width) |=> (mask[DATA_W-1:DATA_W/2] == '0));

  // R8: zero operand against zero never passes
  p_zero_self_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && zero_mode && opa == '0) |=> (mask == '0));

  // R9: acceptance yields a valid result; stall holds it
  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(mask)));

  // R10: reset empties the output register
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && mask == '0));

endmodule

// File: tb/simd_gt_cmp_tb_top.sv
module simd_gt_cmp_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, half_width, zero_mode, out_valid, out_ready;
  logic [127:0] opa, opb, mask;
  logic [1:0]   lane_sz, num_kind;

  always #2 clk = ~clk;

  simd_gt_cmp dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .lane_sz(lane_sz), .num_kind(num_kind),
    .half_width(half_width), .zero_mode(zero_mode), .out_valid(out_valid),
    .out_ready(out_ready), .mask(mask)
  );

  int           checks = 0, errors = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  bit           bp_en = 1'b0;
  bit           held = 1'b0;
  logic [127:0] held_mask;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic longint fp_key(input logic [31:0] x, output bit nan);
    longint m;
    nan = (x[30:23] == 8'hff) && (x[22:0] != 0);
    m = (x[30:23] == 0) ? 0 : longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz, input logic [1:0] kind,
                                         input bit half, input bit zm);
    logic [127:0] r = '0;
    logic [127:0] bb = zm ? '0 : b;
    if (kind[1]) begin
      for (int w = 0; w < 4; w++) begin
        bit na, nb;
        longint ka, kb;
        ka = fp_key(a[32*w +: 32], na);
        kb = fp_key(bb[32*w +: 32], nb);
        if (!na && !nb && ka > kb) r[32*w +: 32] = '1;
      end
    end else begin
      int lw = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
      for (int i = 0; i < 128 / lw; i++) begin
        logic [63:0] av, bv;
        longint sa, sb;
        av = 64'(a >> (i * lw)) & ((64'd1 << lw) - 1);
        bv = 64'(bb >> (i * lw)) & ((64'd1 << lw) - 1);
        sa = longint'(av);
        sb = longint'(bv);
        if (kind == 2'b00) begin
          if (av[lw-1]) sa = sa - (longint'(1) << lw);
          if (bv[lw-1]) sb = sb - (longint'(1) << lw);
        end
        if (sa > sb) for (int k = 0; k < lw; k++) r[i*lw + k] = 1'b1;
      end
    end
    if (half) r[127:64] = '0;
    return r;
  endfunction

  task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                      input logic [1:0] kind, input bit half, input bit zm, input string tag);
    bit ok;
    @(negedge clk);
    opa = a; opb = b; lane_sz = sz; num_kind = kind; half_width = half; zero_mode = zm;
    in_valid = 1'b1;
    exp_q.push_back(model(a, b, sz, kind, half, zm));
    tag_q.push_back(tag);
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  // output consumer: random stalls when enabled
  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor: scoreboard compare and stall stability
  always @(negedge clk) begin
    if (!rst) begin
      if (held && out_valid) chk(mask == held_mask, "R9 stall hold", mask, held_mask);
      held = out_valid && !out_ready;
      held_mask = mask;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected result", mask, '0);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(mask === e, t, mask, e);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    opa = '0; opb = '0; lane_sz = 2'b00; num_kind = 2'b00; half_width = 1'b0; zero_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset valid", {127'd0, out_valid}, '0);
    chk(mask == '0, "R10 reset mask", mask, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready when empty", {127'd0, in_ready}, 128'd1);

    // R1 equality and strictness
    send({4{32'h1234_5678}}, {4{32'h1234_5678}}, 2'b00, 2'b00, 0, 0, "R1 equal bytes");
    send({4{32'h0000_0005}}, {4{32'h0000_0004}}, 2'b10, 2'b01, 0, 0, "R1 greater by one");
    // R4 signed vs unsigned on sign bit
    send({16{8'h80}}, {16{8'h01}}, 2'b00, 2'b00, 0, 0, "R4 signed byte");
    send({16{8'h80}}, {16{8'h01}}, 2'b00, 2'b01, 0, 0, "R4 unsigned byte");
    // R3 lane size chaining: high part equal, low differs
    send({8{16'h7f01}}, {8{16'h7f00}}, 2'b01, 2'b00, 0, 0, "R3 half lanes");
    send({4{32'h8000_0001}}, {4{32'h8000_0000}}, 2'b10, 2'b00, 0, 0, "R3 word lanes");
    send({4{32'h0100_00ff}}, {4{32'h00ff_ff00}}, 2'b11, 2'b01, 0, 0, "R3 size code 11");
    send(128'h00ff_0100_ff00_8000_0001_7fff_fffe_0000, 128'h0100_00ff_0000_7fff_0000_8000_ffff_0001,
         2'b01, 2'b00, 0, 0, "R2 mixed half lanes");
    // R4/R5/R6 floating point
    send({32'h3f80_0000, 32'hbf80_0000, 32'h4000_0000, 32'h7f80_0000},
         {32'hbf80_0000, 32'h3f80_0000, 32'h3f80_0000, 32'h4000_0000}, 2'b00, 2'b10, 0, 0, "R4 fp basic");
    send({32'hc000_0000, 32'hbf80_0000, 32'hff80_0000, 32'h8000_0000},
         {32'hbf80_0000, 32'hc000_0000, 32'hbf80_0000, 32'hbf80_0000}, 2'b00, 2'b11, 0, 0, "R4 fp negatives");
    send({32'h7fc0_0000, 32'h3f80_0000, 32'h7f80_0001, 32'hffc0_0000},
         {32'h3f80_0000, 32'h7fc0_0000, 32'h0000_0000, 32'hff80_0000}, 2'b00, 2'b10, 0, 0, "R5 fp NaN");
    send({32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001},
         {32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h8000_0001}, 2'b00, 2'b10, 0, 0, "R6 fp zeros denormals");
    send({32'h0080_0000, 32'h8000_0000, 32'h0000_0000, 32'h807f_ffff},
         {32'h007f_ffff, 32'h8080_0000, 32'h8080_0000, 32'h8080_0000}, 2'b00, 2'b10, 0, 0, "R6 fp smallest normal");
    // R7 narrow form
    send({16{8'h7f}}, {16{8'h00}}, 2'b00, 2'b00, 1, 0, "R7 half width");
    send({4{32'h3f80_0000}}, '0, 2'b10, 2'b10, 1, 0, "R7 half width fp");
    // R8 zero mode ignores opb
    send({16{8'hff}}, {16{8'h80}}, 2'b00, 2'b00, 0, 1, "R8 zero signed");
    send({16{8'hff}}, {16{8'hff}}, 2'b00, 2'b01, 0, 1, "R8 zero unsigned opb high");
    send({32'h3f80_0000, 32'hbf80_0000, 32'h0000_0001, 32'h7fc0_0000},
         {4{32'h7f80_0000}}, 2'b00, 2'b10, 0, 1, "R8 zero fp");

    // random with back-pressure
    bp_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 0) b = a ^ ({$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
                               & {$urandom, $urandom, $urandom, $urandom});
      if (n % 5 == 0) a[31:0] = {a[31], 8'h00, a[22:0]};
      send(a, b, 2'($urandom), 2'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0),
           "R2 R3 R4 R9 random");
    end
    bp_en = 1'b0;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results delivered", 128'(exp_q.size()), '0);
    summary();
    $finish;
  end

endmodule